// File: doc/BRIEF.md
# 8-bit ALU Condition Flag Unit

This block forms the five condition flags of an 8-bit arithmetic and logic unit and keeps them in a flag register. It receives the two operands, a carry input and a 4-bit operation code. From these it works out the result internally, only as far as the flags need it: sign, zero, nibble (auxiliary) carry, even parity and carry. When the update strobe is high at a rising clock edge, the register takes the new flags. Some operations change only some of the flags. The rest keep their old values.

The stored flags are driven out as separate bits and as a packed byte with a fixed layout. A neighbouring unit can push and pop that byte as one word. The block does not include the result write-back path or any instruction decoding.

Operation codes: 0 ADD, 1 ADD with carry, 2 SUB, 3 SUB with borrow, 4 COMPARE, 5 AND, 6 OR, 7 XOR, 8 rotate left, 9 rotate right. Codes 10 to 15 are reserved.

Top module: `alu_flag_unit`

## Requirements
- R1: A synchronous reset clears all five flags, so the packed byte reads 8'h02.
- R2: When the update strobe is low at a clock edge, every flag keeps its value.
- R3: For codes 0 to 7, sign takes bit 7 of the result, zero is 1 only when all 8 result bits are 0, and parity is 1 when the result holds an even number of ones.
- R4: ADD (code 0) forms A+B and ADD with carry (code 1) forms A+B+cin. Carry is the carry out of bit 7. The nibble carry is the carry out of bit 3 into bit 4.
- R5: SUB (code 2) forms A-B and SUB with borrow (code 3) forms A-B-cin. Carry is 1 on a borrow, that is when A < B (+cin). The nibble carry is 1 when the low nibble borrows from bit 4, that is when A[3:0] < B[3:0] (+cin).
- R6: COMPARE (code 4) sets every flag exactly as SUB (code 2) does for the same operands. For example, equal operands give zero=1 and carry=0.
- R7: AND, OR and XOR (codes 5, 6, 7) clear carry and nibble carry.
- R8: Rotate left (code 8) loads carry with A[7]. Rotate right (code 9) loads carry with A[0]. Sign, zero, nibble carry and parity keep their values.
- R9: Codes 10 to 15 leave all flags unchanged, even when the update strobe is high.
- R10: The packed byte holds sign at bit 7, zero at bit 6, nibble carry at bit 4, parity at bit 2 and carry at bit 0. Bit 1 is constant 1. Bits 3 and 5 are constant 0.
- R11: New flags appear at the outputs just after the rising edge on which the update strobe is sampled high. They appear no earlier than that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opa | input | 8 | Operand A |
| opb | input | 8 | Operand B |
| cin | input | 1 | Carry input for the with-carry and with-borrow codes |
| op | input | 4 | Operation code |
| upd_en | input | 1 | Flag update strobe |
| flag_byte | output | 8 | Packed flag byte |
| f_s | output | 1 | Sign flag |
| f_z | output | 1 | Zero flag |
| f_ac | output | 1 | Nibble carry flag |
| f_p | output | 1 | Even parity flag |
| f_cy | output | 1 | Carry flag |

## Verification
Every flag is due one edge after its stimulus. Inputs are applied on the falling edge, the register captures them on the next rising edge, and the outputs are compared on the falling edge that follows. So each result is checked half a cycle after it becomes visible, and before the next stimulus is applied. Between checks, a bench model of the flag register tracks which flags each code is allowed to change. This lets the partial updates of rotates, the hold with the strobe low, and the reserved codes be checked at the outputs in the same cycle-aligned way.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int NFLAG  = 5;

  // packed byte positions (consumed by push/pop of the flag word)
  localparam int POS_S  = 7;
  localparam int POS_Z  = 6;
  localparam int POS_AC = 4;
  localparam int POS_P  = 2;
  localparam int POS_CY = 0;
  localparam int POS_ONE = 1;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
    OP_CMP = 4'd4, OP_AND = 4'd5, OP_OR  = 4'd6, OP_XOR = 4'd7,
    OP_ROL = 4'd8, OP_ROR = 4'd9
  } op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  typedef struct packed {
    logic [DATA_W-1:0] res;
    logic              co;
    logic              hc;
  } arith_t;

  function automatic logic f_even_par(input logic [DATA_W-1:0] v);
    return ~(^v);
  endfunction

  function automatic arith_t f_add(input logic [DATA_W-1:0] a,
                                   input logic [DATA_W-1:0] b,
                                   input logic c);
    arith_t r;
    logic [DATA_W:0] full;
    logic [NIB_W:0]  low;
    full  = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, c};
    low   = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, c};
    r.res = full[DATA_W-1:0];
    r.co  = full[DATA_W];
    r.hc  = low[NIB_W];
    return r;
  endfunction

  function automatic arith_t f_sub(input logic [DATA_W-1:0] a,
                                   input logic [DATA_W-1:0] b,
                                   input logic c);
    arith_t r;
    logic [DATA_W:0] full;
    logic [NIB_W:0]  low;
    full  = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, c};
    low   = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - {{NIB_W{1'b0}}, c};
    r.res = full[DATA_W-1:0];
    r.co  = full[DATA_W];
    r.hc  = low[NIB_W];
    return r;
  endfunction
endpackage

// File: rtl/alu_flag_calc.sv
module alu_flag_calc
  import alu_flag_pkg::*;
(
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              cin,
  input  logic [3:0]        op,
  output flags_t            nxt_flags,
  output flags_t            wr_mask
);
  arith_t            sum_r;
  arith_t            dif_r;
  logic              use_c;
  logic [DATA_W-1:0] res;

  assign use_c = (op == OP_ADC) || (op == OP_SBB);
  assign sum_r = f_add(opa, opb, use_c & cin);
  assign dif_r = f_sub(opa, opb, use_c & cin);

  always_comb begin
    res       = '0;
    nxt_flags = '0;
    wr_mask   = '0;
    case (op)
      OP_ADD, OP_ADC: begin
        res          = sum_r.res;
        nxt_flags.cy = sum_r.co;
        nxt_flags.ac = sum_r.hc;
        wr_mask      = '1;
      end
      OP_SUB, OP_SBB, OP_CMP: begin
        res          = dif_r.res;
        nxt_flags.cy = dif_r.co;
        nxt_flags.ac = dif_r.hc;
        wr_mask      = '1;
      end
      OP_AND: begin res = opa & opb; wr_mask = '1; end
      OP_OR:  begin res = opa | opb; wr_mask = '1; end
      OP_XOR: begin res = opa ^ opb; wr_mask = '1; end
      OP_ROL: begin
        res          = {opa[DATA_W-2:0], opa[DATA_W-1]};
        nxt_flags.cy = opa[DATA_W-1];
        wr_mask.cy   = 1'b1;
      end
      OP_ROR: begin
        res          = {opa[0], opa[DATA_W-1:1]};
        nxt_flags.cy = opa[0];
        wr_mask.cy   = 1'b1;
      end
      default: wr_mask = '0;
    endcase
    nxt_flags.s = res[DATA_W-1];
    nxt_flags.z = (res == '0);
    nxt_flags.p = f_even_par(res);
  end

  always_comb begin
    if (op == OP_AND || op == OP_OR || op == OP_XOR)
      assert (nxt_flags.cy == 1'b0 && nxt_flags.ac == 1'b0); // R7
  end
endmodule

// File: rtl/alu_flag_store.sv
module alu_flag_store
  import alu_flag_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   upd_en,
  input  flags_t nxt_flags,
  input  flags_t wr_mask,
  output flags_t cur_flags
);
  always_ff @(posedge clk) begin
    if (rst)
      cur_flags <= '0;
    else if (upd_en)
      cur_flags <= (cur_flags & ~wr_mask) | (nxt_flags & wr_mask);
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> cur_flags == '0); // R1
  AST_HOLD_NO_UPD: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(cur_flags)); // R2
  AST_ZERO_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_mask == '0) |=> $stable(cur_flags)); // R9
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin,
  input  logic [3:0]   op,
  input  logic         upd_en,
  output logic [7:0]   flag_byte,
  output logic         f_s,
  output logic         f_z,
  output logic         f_ac,
  output logic         f_p,
  output logic         f_cy
);
  flags_t nxt_flags;
  flags_t wr_mask;
  flags_t cur_flags;

  alu_flag_calc u_calc (
    .opa(opa), .opb(opb), .cin(cin), .op(op),
    .nxt_flags(nxt_flags), .wr_mask(wr_mask)
  );

  alu_flag_store u_store (
    .clk(clk), .rst(rst), .upd_en(upd_en),
    .nxt_flags(nxt_flags), .wr_mask(wr_mask), .cur_flags(cur_flags)
  );

  assign f_s  = cur_flags.s;
  assign f_z  = cur_flags.z;
  assign f_ac = cur_flags.ac;
  assign f_p  = cur_flags.p;
  assign f_cy = cur_flags.cy;

  always_comb begin
    flag_byte          = '0;
    flag_byte[POS_S]   = cur_flags.s;
    flag_byte[POS_Z]   = cur_flags.z;
    flag_byte[POS_AC]  = cur_flags.ac;
    flag_byte[POS_P]   = cur_flags.p;
    flag_byte[POS_CY]  = cur_flags.cy;
    flag_byte[POS_ONE] = 1'b1;
  end

  AST_PACK_FIXED: assert property (@(posedge clk) disable iff (rst)
    flag_byte[1] && !flag_byte[3] && !flag_byte[5]); // R10
  AST_CMP_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op == OP_CMP && opa == opb) |=> (f_z && !f_cy && !f_ac && f_p)); // R6
  AST_LOGIC_NO_CY: assert property (@(posedge clk) disable iff (rst)
    (upd_en && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> (!f_cy && !f_ac)); // R7
  AST_ROT_KEEP: assert property (@(posedge clk) disable iff (rst)
    (upd_en && (op == OP_ROL || op == OP_ROR))
      |=> ($stable(f_s) && $stable(f_z) && $stable(f_ac) && $stable(f_p))); // R8
  AST_ROL_CY: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op == OP_ROL) |=> (f_cy == $past(opa[W-1]))); // R8
endmodule

// File: tb/alu_flag_unit_test.sv
module alu_flag_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opa = '0, opb = '0;
  logic       cin = 1'b0;
  logic [3:0] op = '0;
  logic       upd_en = 1'b0;
  logic [7:0] flag_byte;
  logic       f_s, f_z, f_ac, f_p, f_cy;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [4:0] model; // {s,z,ac,p,cy}

  always #10 clk = ~clk;

  alu_flag_unit uut (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .cin(cin), .op(op),
    .upd_en(upd_en), .flag_byte(flag_byte), .f_s(f_s), .f_z(f_z),
    .f_ac(f_ac), .f_p(f_p), .f_cy(f_cy)
  );

  function automatic bit even_ones(input int v);
    int k = 0;
    for (int i = 0; i < 8; i++) if ((v >> i) % 2 == 1) k++;
    return (k % 2) == 0;
  endfunction

  function automatic logic [4:0] ref_next(input logic [4:0] cur, input int o,
                                          input int a, input int b, input int c);
    int r;
    logic [4:0] n = cur;
    int cc = (o == 1 || o == 3) ? c : 0;
    case (o)
      0, 1: begin
        r = a + b + cc;
        n[1] = r > 255; n[0] = 1'b0; n[2] = ((a % 16) + (b % 16) + cc) > 15;
        n = {1'b0, 1'b0, (((a % 16) + (b % 16) + cc) > 15) ? 1'b1 : 1'b0, 1'b0, (r > 255) ? 1'b1 : 1'b0};
        r = r % 256;
      end
      2, 3, 4: begin
        n = {1'b0, 1'b0, ((a % 16) < (b % 16) + cc) ? 1'b1 : 1'b0, 1'b0, (a < b + cc) ? 1'b1 : 1'b0};
        r = (a - b - cc + 512) % 256;
      end
      5: begin r = a & b; n = '0; end
      6: begin r = a | b; n = '0; end
      7: begin r = a ^ b; n = '0; end
      8: begin n[0] = (a >= 128); return n; end
      9: begin n[0] = (a % 2 == 1); return n; end
      default: return cur;
    endcase
    n[4] = (r >= 128);
    n[3] = (r == 0);
    n[1] = even_ones(r);
    return n;
  endfunction

  function automatic string tag_of(input int o);
    case (o)
      0, 1: return "R4/R3";
      2, 3: return "R5/R3";
      4: return "R6";
      5, 6, 7: return "R7/R3";
      8, 9: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req);
    logic [7:0] exp_b;
    exp_b = {model[4], model[3], 1'b0, model[2], 1'b0, model[1], 1'b1, model[0]};
    n_run++;
    if (flag_byte !== exp_b || {f_s, f_z, f_ac, f_p, f_cy} !== model) begin
      n_fail++;
      $display("FAIL %s: byte=%h bits=%b expected byte=%h bits=%b",
               req, flag_byte, {f_s, f_z, f_ac, f_p, f_cy}, exp_b, model);
    end
  endtask

  // drive at falling edge, capture at rising edge, compare at next falling edge
  task automatic step(input int o, input int a, input int b, input int c,
                      input bit en, input string req);
    opa = a[7:0]; opb = b[7:0]; cin = c[0]; op = o[3:0]; upd_en = en;
    @(posedge clk);
    if (en) model = ref_next(model, o, a, b, c);
    @(negedge clk);
    check(req);
  endtask

  initial begin
    int seed;
    int o;
    seed = 32'h5EED;
    void'($urandom(seed));
    model = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 reset byte 02");                                    // R1
    // R11: no change before the capturing edge
    opa = 8'hFF; opb = 8'h01; op = 4'd0; upd_en = 1'b1;
    #5; n_run++;
    if (flag_byte !== 8'h02) begin
      n_fail++; $display("FAIL R11: early change byte=%h expected 02", flag_byte);
    end
    @(posedge clk); model = ref_next(model, 0, 255, 1, 0);
    @(negedge clk); check("R11/R4 FF+01");
    step(0, 8'h0F, 8'h01, 0, 1, "R4 nibble carry");
    step(1, 8'h7F, 8'h00, 1, 1, "R4 adc carry-in");
    step(2, 8'h00, 8'h01, 0, 1, "R5 borrow");
    step(3, 8'h10, 8'h00, 1, 1, "R5 sbb nibble borrow");
    step(4, 8'h5A, 8'h5A, 0, 1, "R6 equal compare");
    step(4, 8'h20, 8'h31, 1, 1, "R6 compare ignores cin");
    step(5, 8'hF0, 8'h0F, 0, 1, "R7 and zero");
    step(6, 8'h80, 8'h01, 0, 1, "R7 or");
    step(2, 8'h00, 8'h01, 0, 1, "R5 set cy");
    step(8, 8'h80, 8'h00, 0, 1, "R8 rol cy=1 others kept");
    step(9, 8'hFE, 8'h00, 0, 1, "R8 ror cy=0");
    step(0, 8'h01, 8'h01, 0, 0, "R2 hold");
    step(12, 8'h00, 8'h00, 0, 1, "R9 reserved");
    step(15, 8'hFF, 8'hFF, 1, 1, "R9 reserved");
    step(7, 8'hAA, 8'h55, 0, 1, "R10/R7 xor layout");
    for (int i = 0; i < 400; i++) begin
      o = $urandom % 16;
      step(o, $urandom % 256, $urandom % 256, $urandom % 2,
           ($urandom % 4) != 0, tag_of(o));
    end
    rst = 1'b1; @(posedge clk); model = '0; @(negedge clk); rst = 1'b0;
    check("R1 reset again");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule